// File: doc/BRIEF.md
# D-Channel Access and Collision Monitor

This block decides, frame by frame, whether an HDLC transmitter in a terminal on a time-multiplexed ISDN subscriber bus may put data on the D channel, and withdraws that permission when it may not. A separate frame counter supplies the timing: a frame-start pulse, a per-bit strobe, the byte number within the frame and the bit number within the byte, counting 7 down to 0. The monitor watches the downstream serial line and the upstream bit that the terminal drives.

In every frame the monitor records the two upstream D-channel bits it sent. The downstream control byte that closes channel 2 then returns an echo of those two bits and a stop/go flag. If this terminal drove the D channel in that frame and the echo differs from what it sent, the monitor emits a one-cycle collision pulse. It also keeps the transmit permission low until the HDLC side acknowledges the abort. The permission otherwise follows the stop/go flag of the most recent frame.

Top module: `dch_access_mon`

## Requirements
- R1: While rst_ni is low and in the first cycle after its release, tx_permit_o and collision_o are 0.
- R2: When dd_i is 0 at the strobe of bit 5 in byte CI_BYTE (default 11), tx_permit_o is 1 from the next cycle on, unless a collision hold is pending.
- R3: When dd_i is 1 at the strobe of bit 5 in byte CI_BYTE, tx_permit_o is 0 from the next cycle on.
- R4: The sent D-channel bits are taken at the strobes of bits 7 and 6 in byte D_BYTE (default 3). A bit with du_drv_i low counts as a sent 1, because the line is open-drain.
- R5: dd_i at bits 7 and 6 of byte CI_BYTE echoes the two sent bits in the same order. In a frame where this terminal drove the D channel, a mismatch sets collision_o high for exactly the one cycle after the bit 6 strobe.
- R6: In a frame where du_drv_i was low at both D-bit strobes, no collision is reported. The driven state is cleared by ts_frame_i.
- R7: After a collision, tx_permit_o stays 0 until abort_ack_i is high at a clock edge. If a new collision is found in the same cycle as the acknowledge, the collision takes precedence and the hold remains.
- R8: The remaining downstream bits have no effect on either output; this includes bit 4 of byte CI_BYTE, the blocked/available flag. Upstream bits outside the two D-bit strobes have no effect either.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ts_frame_i | input | 1 | Frame start pulse from the frame counter |
| ts_bit_en_i | input | 1 | One-cycle strobe per bit period |
| ts_byte_i | input | BYTE_W | Byte number within the frame |
| ts_bit_i | input | 3 | Bit number within the byte, 7 first |
| dd_i | input | 1 | Downstream serial data |
| du_tx_i | input | 1 | Upstream bit this terminal presents |
| du_drv_i | input | 1 | This terminal enables its upstream driver |
| abort_ack_i | input | 1 | HDLC side acknowledges the abort |
| tx_permit_o | output | 1 | The D channel may be used |
| collision_o | output | 1 | One-cycle collision pulse |

## Verification
The assertions take the frame counter as well-formed. Each (byte, bit) position gets at most one strobe per frame, ts_frame_i falls between the end of one frame's channel-2 control byte and the next frame's D slot, and every bit value is stable during its strobe cycle. The bench builds each frame as a complete walk of all twelve bytes in descending bit order, one strobe every second cycle, with the frame pulse on the first strobe. The sweep runs over every combination of driver enables, sent bits, echo, stop/go, blocked flag and acknowledge timing. Filler values outside the decoded positions are chosen so that a wrongly decoded slot would change the outcome.

// File: rtl/dch_pkg.sv
package dch_pkg;
  typedef struct packed {
    logic [1:0] d_slot;  // [1]: D bit 7, [0]: D bit 6
    logic       echo_hi;
    logic       echo_lo;
    logic       sg;
  } slot_stb_t;
endpackage

// File: rtl/dch_slot_decode.sv
module dch_slot_decode
  import dch_pkg::*;
#(
  parameter int unsigned FRAME_BYTES = 12,
  parameter int unsigned D_BYTE      = 3,
  parameter int unsigned CI_BYTE     = 11,
  localparam int unsigned BYTE_W     = $clog2(FRAME_BYTES)
) (
  input  logic              bit_en_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [2:0]        bit_i,
  output slot_stb_t         stb_o
);
  localparam logic [BYTE_W-1:0] DB = BYTE_W'(D_BYTE);
  localparam logic [BYTE_W-1:0] CB = BYTE_W'(CI_BYTE);

  logic in_d, in_ci;

  always_comb begin
    in_d  = bit_en_i && (byte_i == DB);
    in_ci = bit_en_i && (byte_i == CB);
    stb_o.d_slot[1] = in_d  && (bit_i == 3'd7);
    stb_o.d_slot[0] = in_d  && (bit_i == 3'd6);
    stb_o.echo_hi   = in_ci && (bit_i == 3'd7);
    stb_o.echo_lo   = in_ci && (bit_i == 3'd6);
    stb_o.sg        = in_ci && (bit_i == 3'd5);
  end
endmodule

// File: rtl/dch_tx_latch.sv
module dch_tx_latch #(
  parameter int unsigned NBITS = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_i,
  input  logic [NBITS-1:0] stb_i,
  input  logic             tx_i,
  input  logic             drv_i,
  output logic [NBITS-1:0] sent_o,
  output logic             drove_o
);
  logic [NBITS-1:0] drv_q;

  for (genvar i = 0; i < NBITS; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sent_o[i] <= 1'b1;
        drv_q[i]  <= 1'b0;
      end else if (stb_i[i]) begin
        sent_o[i] <= drv_i ? tx_i : 1'b1;  // open drain: released bit reads 1
        drv_q[i]  <= drv_i;
      end else if (frame_i) begin
        drv_q[i]  <= 1'b0;
      end
    end
  end

  assign drove_o = |drv_q;
endmodule

// File: rtl/dch_echo_check.sv
module dch_echo_check (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       echo_hi_i,
  input  logic       echo_lo_i,
  input  logic       dd_i,
  input  logic [1:0] sent_i,
  input  logic       drove_i,
  output logic       mismatch_o,
  output logic       coll_o
);
  logic echo_hi_q;

  assign mismatch_o = echo_lo_i && drove_i && ({echo_hi_q, dd_i} != sent_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      echo_hi_q <= 1'b1;
      coll_o    <= 1'b0;
    end else begin
      if (echo_hi_i) echo_hi_q <= dd_i;
      coll_o <= mismatch_o;
    end
  end
endmodule

// File: rtl/dch_access_ctrl.sv
module dch_access_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sg_stb_i,
  input  logic dd_i,
  input  logic mismatch_i,
  input  logic ack_i,
  output logic permit_o
);
  logic go_q, hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      go_q   <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      if (sg_stb_i) go_q <= ~dd_i;
      if (mismatch_i)  hold_q <= 1'b1;  // new collision beats ack
      else if (ack_i)  hold_q <= 1'b0;
    end
  end

  assign permit_o = go_q && !hold_q;
endmodule

// File: rtl/dch_access_mon.sv
module dch_access_mon
  import dch_pkg::*;
#(
  parameter int unsigned FRAME_BYTES = 12,
  parameter int unsigned D_BYTE      = 3,
  parameter int unsigned CI_BYTE     = 11,
  localparam int unsigned BYTE_W     = $clog2(FRAME_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ts_frame_i,
  input  logic              ts_bit_en_i,
  input  logic [BYTE_W-1:0] ts_byte_i,
  input  logic [2:0]        ts_bit_i,
  input  logic              dd_i,
  input  logic              du_tx_i,
  input  logic              du_drv_i,
  input  logic              abort_ack_i,
  output logic              tx_permit_o,
  output logic              collision_o
);
  slot_stb_t  stb;
  logic [1:0] sent;
  logic       drove;
  logic       mismatch;

  dch_slot_decode #(
    .FRAME_BYTES(FRAME_BYTES), .D_BYTE(D_BYTE), .CI_BYTE(CI_BYTE)
  ) u_dec (
    .bit_en_i(ts_bit_en_i), .byte_i(ts_byte_i), .bit_i(ts_bit_i), .stb_o(stb)
  );

  dch_tx_latch #(.NBITS(2)) u_txl (
    .clk_i(clk_i), .rst_ni(rst_ni), .frame_i(ts_frame_i), .stb_i(stb.d_slot),
    .tx_i(du_tx_i), .drv_i(du_drv_i), .sent_o(sent), .drove_o(drove)
  );

  dch_echo_check u_echo (
    .clk_i(clk_i), .rst_ni(rst_ni), .echo_hi_i(stb.echo_hi), .echo_lo_i(stb.echo_lo),
    .dd_i(dd_i), .sent_i(sent), .drove_i(drove), .mismatch_o(mismatch),
    .coll_o(collision_o)
  );

  dch_access_ctrl u_acc (
    .clk_i(clk_i), .rst_ni(rst_ni), .sg_stb_i(stb.sg), .dd_i(dd_i),
    .mismatch_i(mismatch), .ack_i(abort_ack_i), .permit_o(tx_permit_o)
  );
endmodule

// File: rtl/dch_access_mon_chk.sv
module dch_access_mon_chk #(
  parameter int unsigned FRAME_BYTES = 12,
  parameter int unsigned CI_BYTE     = 11,
  localparam int unsigned BYTE_W     = $clog2(FRAME_BYTES)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ts_bit_en_i,
  input logic [BYTE_W-1:0] ts_byte_i,
  input logic [2:0]        ts_bit_i,
  input logic              dd_i,
  input logic              abort_ack_i,
  input logic              drove,
  input logic              tx_permit_o,
  input logic              collision_o
);
  logic ci_slot;
  assign ci_slot = ts_bit_en_i && (ts_byte_i == BYTE_W'(CI_BYTE));

  // R5: pulse is one cycle wide
  a_r5_one_cycle_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    collision_o |=> !collision_o);

  // R5: pulse only follows the second echo bit
  a_r5_after_echo_lo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    collision_o |-> $past(ci_slot && ts_bit_i == 3'd6));

  // R6: no collision without a driven frame
  a_r6_needs_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    collision_o |-> $past(drove));

  // R7: collision withdraws permission at once
  a_r7_coll_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    collision_o |-> !tx_permit_o);

  // R2: permission rises only on go or ack
  a_r2_rise_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_permit_o) |-> $past(ci_slot && ts_bit_i == 3'd5 && !dd_i) || $past(abort_ack_i));

  // R3: permission falls only on stop or collision
  a_r3_fall_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_permit_o) |-> $past(ci_slot && ts_bit_i == 3'd5 && dd_i) || collision_o);
endmodule

bind dch_access_mon dch_access_mon_chk #(
  .FRAME_BYTES(FRAME_BYTES), .CI_BYTE(CI_BYTE)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ts_bit_en_i(ts_bit_en_i), .ts_byte_i(ts_byte_i),
  .ts_bit_i(ts_bit_i), .dd_i(dd_i), .abort_ack_i(abort_ack_i), .drove(drove),
  .tx_permit_o(tx_permit_o), .collision_o(collision_o)
);

// File: tb/dch_access_mon_tb.sv
module dch_access_mon_tb;
  localparam int unsigned FRAME_BYTES = 12;
  localparam int unsigned D_BYTE      = 3;
  localparam int unsigned CI_BYTE     = 11;
  localparam int unsigned BYTE_W      = $clog2(FRAME_BYTES);

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic ts_frame_i = 1'b0, ts_bit_en_i = 1'b0;
  logic [BYTE_W-1:0] ts_byte_i = '0;
  logic [2:0] ts_bit_i = '0;
  logic dd_i = 1'b1, du_tx_i = 1'b0, du_drv_i = 1'b0, abort_ack_i = 1'b0;
  logic tx_permit_o, collision_o;

  int vec = 0, errs = 0;
  bit done = 0;
  logic go_m = 0, hold_m = 0;

  always #5 clk_i = ~clk_i;

  dch_access_mon #(.FRAME_BYTES(FRAME_BYTES), .D_BYTE(D_BYTE), .CI_BYTE(CI_BYTE)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .ts_frame_i(ts_frame_i), .ts_bit_en_i(ts_bit_en_i),
    .ts_byte_i(ts_byte_i), .ts_bit_i(ts_bit_i), .dd_i(dd_i), .du_tx_i(du_tx_i),
    .du_drv_i(du_drv_i), .abort_ack_i(abort_ack_i), .tx_permit_o(tx_permit_o),
    .collision_o(collision_o)
  );

  task automatic chk(string req, logic act, logic exp);
    vec++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // drv/tx index [1]=D bit 7, [0]=D bit 6; echo likewise; am: 0 none, 1 ack at end, 2 ack with echo bit 6
  task automatic run_frame(logic [1:0] drv, logic [1:0] tx, logic [1:0] echo,
                           logic sg, logic ab, int am);
    logic [1:0] sent;
    logic coll;
    sent[1] = drv[1] ? tx[1] : 1'b1;
    sent[0] = drv[0] ? tx[0] : 1'b1;
    coll = (|drv) && (echo != sent);
    for (int b = 0; b < FRAME_BYTES; b++) begin
      for (int k = 7; k >= 0; k--) begin
        @(negedge clk_i);
        chk("R5", collision_o, 1'b0);
        ts_bit_en_i = 1'b1;
        ts_frame_i  = (b == 0 && k == 7);
        ts_byte_i   = BYTE_W'(b);
        ts_bit_i    = 3'(k);
        abort_ack_i = (am == 2 && b == CI_BYTE && k == 6);
        dd_i        = (b + k) % 2 == 1;  // filler, R8
        du_drv_i    = 1'b1;              // filler drive of 0, R8
        du_tx_i     = 1'b0;
        if (b == D_BYTE && k >= 6) begin
          du_drv_i = drv[k-6];
          du_tx_i  = tx[k-6];
        end
        if (b == CI_BYTE) begin
          if (k >= 6) dd_i = echo[k-6];
          if (k == 5) dd_i = sg;
          if (k == 4) dd_i = ab;
        end
        @(negedge clk_i);
        ts_bit_en_i = 1'b0;
        ts_frame_i  = 1'b0;
        abort_ack_i = 1'b0;
        if (b == CI_BYTE && k == 6) begin
          if (coll) hold_m = 1;
          else if (am == 2) hold_m = 0;
          chk("R5", collision_o, coll);
          chk("R7", tx_permit_o, go_m && !hold_m);
        end else if (b == CI_BYTE && k == 5) begin
          go_m = !sg;
          chk(sg ? "R3" : "R2", tx_permit_o, go_m && !hold_m);
        end else begin
          chk("R6", collision_o, 1'b0);
        end
      end
    end
    if (am == 1) begin
      @(negedge clk_i);
      abort_ack_i = 1'b1;
      @(negedge clk_i);
      abort_ack_i = 1'b0;
      hold_m = 0;
      chk("R7", tx_permit_o, go_m);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1", tx_permit_o, 1'b0);
    chk("R1", collision_o, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", tx_permit_o, 1'b0);
    chk("R1", collision_o, 1'b0);
    for (int am = 0; am < 3; am++)
      for (int d = 0; d < 4; d++)
        for (int t = 0; t < 4; t++)
          for (int e = 0; e < 4; e++)
            for (int s = 0; s < 2; s++)
              for (int a = 0; a < 2; a++)
                run_frame(2'(d), 2'(t), 2'(e), 1'(s), 1'(a), am);
    // R4: released bits read as 1, so an all-ones echo with no driven 0 is clean
    run_frame(2'b01, 2'b11, 2'b11, 1'b0, 1'b0, 1);
    chk("R4", tx_permit_o, 1'b1);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, errs);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vec, errs);
      $finish;
    end
  end
endmodule